// File: doc/BRIEF.md
# Load/Store Effective Address and Lane Steering Unit

This unit sits between the decode stage and a 16-bit little-endian data memory. For each load or store request it decodes the 8-bit memory-operand mode and works out the effective byte address. It also works out whether a base register must be updated afterwards, and with what value. It then drives one memory access with byte lane enables. Byte stores send their low byte to the selected lane. The unit returns the load result, with byte loads zero-extended. It also handles code-word requests, where the register holds a word index into a 128 kB space.

A request is presented for one cycle together with the value of the register named by `base_sel`, the current stack pointer, the optional immediate and the store data. The memory port is registered, so it is driven in the cycle after the request. Load data and the base-register writeback come out one cycle after that, side by side. If a word data access has an odd address, the unit raises an error pulse instead of making the access. Memory read data must be valid in the same cycle that the port presents a read.

Top module: `memaddr_gen`

## Requirements
- R1: Modes 0x00 to 0x0e access the byte address held in register `mode[3:0]`, and they produce no writeback.
- R2: Mode 0x0f (push) accesses stack pointer minus 2 and writes that same value back to register 14.
- R3: Modes 0x10 to 0x1e access register `mode[3:0]` plus the immediate. Mode 0x1f accesses the immediate as an absolute address. Neither produces a writeback.
- R4: Modes 0x20 to 0x2e access register `mode[3:0]` and then write register plus immediate back to that register. Mode 0x2f (pop) accesses the stack pointer and writes stack pointer plus 2 back to register 14.
- R5: Modes 0x30 to 0xff access stack pointer plus (mode − 0x30), with no writeback.
- R6: `req_kind` encodes 0 word load, 1 word store, 2 byte load, 3 byte store, 4 code-word load and 5 code-word store. Data accesses put 0 on address bit 16. Word accesses enable both lanes (`mem_be`=11) and drive the store data unchanged. Byte accesses enable lane 0 (`01`) for an even address and lane 1 (`10`) for an odd address, and drive the store data's low byte on both lanes.
- R7: A word load returns the whole read word. A byte load returns the lane picked by address bit 0, zero-extended to 16 bits.
- R8: Code-word accesses use byte address {register, 0} over 17 bits. They enable both lanes and never write back.
- R9: A word data access to an odd address raises `misalign_err` for one cycle, in the cycle after the request. It produces no memory access, no load result and no writeback.
- R10: When a load's writeback register equals its destination `req_dst`, the load result is delivered and the writeback is dropped.
- R11: The memory port is driven in the cycle after the request. Load result and writeback appear one cycle later. Kinds 6 and 7 produce nothing. Reset clears every valid and the error output.
- R12: `base_sel` is combinational from the request. It is 14 for modes 0x0f, 0x2f and 0x30 and above. Otherwise it is `mode[3:0]`. Code-word kinds always use `mode[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Access kind (see R6) |
| req_mode | input | 8 | Memory-operand mode; low nibble names the register for code kinds |
| req_dst | input | 4 | Destination register of a load |
| base_sel | output | 4 | Register index whose value must be on `base_val` |
| base_val | input | 16 | Value of register `base_sel` |
| sp_val | input | 16 | Current stack pointer (register 14) |
| imm | input | 16 | Immediate word following the instruction |
| store_data | input | 16 | Data to store |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 17 | Byte address |
| mem_be | output | 2 | Byte lane enables, bit 0 = low byte |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the access cycle |
| misalign_err | output | 1 | Odd word data address, access dropped |
| ld_valid | output | 1 | Load result valid |
| ld_idx | output | 4 | Load destination register |
| ld_data | output | 16 | Load result |
| wb_valid | output | 1 | Base register update valid |
| wb_idx | output | 4 | Register to update |
| wb_data | output | 16 | New register value |

## Verification
The load result and the base-register writeback leave the unit in the same cycle, and they can name the same register. The sweep sets the destination equal to the mode's register in every other pass. This makes post-update loads and push/pop loads into register 14 collide. In those cases the bench expects only the load result. The same sweep runs each mode with an odd stack pointer and with odd register values, so a misalignment falls in the same request as a pending writeback. The bench then requires that the error and no writeback come out.

// File: rtl/mag_pkg.sv
// Shared widths and types of the memory-operand address unit.
// Assumes a 16-bit data word, byte addressing and a 17-bit physical space.
package mag_pkg;
    localparam int DATA_W     = 16;
    localparam int PADDR_W    = DATA_W + 1;
    localparam int REG_W      = 4;
    localparam int MODE_W     = 8;
    localparam int LANES      = DATA_W / 8;
    localparam int LANE_W     = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [MODE_W-1:0] FRAME_BASE = 8'h30;

    typedef enum logic [2:0] {
        K_LDW  = 3'd0,
        K_STW  = 3'd1,
        K_LDB  = 3'd2,
        K_STB  = 3'd3,
        K_LDC  = 3'd4,
        K_STC  = 3'd5
    } kind_e;

    typedef enum logic [2:0] {
        C_IND,
        C_PUSH,
        C_OFS,
        C_ABS,
        C_POST,
        C_POP,
        C_FRAME,
        C_CODE
    } mclass_e;
endpackage

// File: rtl/mag_decode.sv
// Mode decoder: classifies the memory-operand mode and names the register
// whose value the address path needs. Purely combinational.
// Assumes modes at or above FRAME_BASE are all frame-relative.
module mag_decode
    import mag_pkg::*;
#(
    parameter logic [REG_W-1:0] SP_IDX = 4'd14
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              code,
    output mclass_e           cls,
    output logic [REG_W-1:0]  sel
);
    logic last_slot;

    // Low nibble all ones marks the special slot of each 16-mode group.
    assign last_slot = &mode[3:0];

    // Class selection from mode groups.
    always_comb begin
        if (code) begin
            cls = C_CODE;
        end else if (mode >= FRAME_BASE) begin
            cls = C_FRAME;
        end else begin
            unique case (mode[5:4])
                2'd0:    cls = last_slot ? C_PUSH : C_IND;
                2'd1:    cls = last_slot ? C_ABS  : C_OFS;
                2'd2:    cls = last_slot ? C_POP  : C_POST;
                default: cls = C_FRAME;
            endcase
        end
    end

    // Register read index: stack classes use the stack pointer.
    always_comb begin
        unique case (cls)
            C_PUSH, C_POP, C_FRAME: sel = SP_IDX;
            default:                sel = mode[3:0];
        endcase
    end
endmodule

// File: rtl/mag_agu.sv
// Address generator: forms the physical byte address and the base
// register update for one request. Purely combinational.
// Assumes base_val already holds the register that mag_decode selected.
module mag_agu
    import mag_pkg::*;
#(
    parameter logic [REG_W-1:0]  SP_IDX     = 4'd14,
    parameter int                STACK_STEP = 2
) (
    input  mclass_e              cls,
    input  logic [MODE_W-1:0]    mode,
    input  logic [DATA_W-1:0]    base_val,
    input  logic [DATA_W-1:0]    sp_val,
    input  logic [DATA_W-1:0]    imm,
    output logic [PADDR_W-1:0]   paddr,
    output logic                 wb_en,
    output logic [REG_W-1:0]     wb_idx,
    output logic [DATA_W-1:0]    wb_data
);
    localparam logic [DATA_W-1:0] STEP = DATA_W'(STACK_STEP);

    logic [DATA_W-1:0] sp_dec;
    logic [DATA_W-1:0] sp_inc;
    logic [DATA_W-1:0] base_imm;
    logic [DATA_W-1:0] frame_ofs;
    logic [DATA_W-1:0] daddr;

    // Shared adders for all classes.
    always_comb begin
        sp_dec    = sp_val - STEP;
        sp_inc    = sp_val + STEP;
        base_imm  = base_val + imm;
        frame_ofs = {{(DATA_W-MODE_W){1'b0}}, mode - FRAME_BASE};
    end

    // Effective address and writeback selection per class.
    always_comb begin
        daddr   = base_val;
        wb_en   = 1'b0;
        wb_idx  = mode[3:0];
        wb_data = base_imm;
        unique case (cls)
            C_IND:   daddr = base_val;
            C_PUSH:  begin
                daddr   = sp_dec;
                wb_en   = 1'b1;
                wb_idx  = SP_IDX;
                wb_data = sp_dec;
            end
            C_OFS:   daddr = base_imm;
            C_ABS:   daddr = imm;
            C_POST:  begin
                daddr   = base_val;
                wb_en   = 1'b1;
                wb_data = base_imm;
            end
            C_POP:   begin
                daddr   = sp_val;
                wb_en   = 1'b1;
                wb_idx  = SP_IDX;
                wb_data = sp_inc;
            end
            C_FRAME: daddr = sp_val + frame_ofs;
            default: daddr = base_val;
        endcase
    end

    // Code pointers are word indices; data pointers live in the low half.
    assign paddr = (cls == C_CODE) ? {base_val, 1'b0} : {1'b0, daddr};
endmodule

// File: rtl/mag_lane.sv
// Byte lane steering for a little-endian memory port: lane enables and
// write data on the request side, lane extraction on the response side.
// Assumes lane i carries bits [8i+7:8i].
module mag_lane
    import mag_pkg::*;
(
    input  logic              wr_byte,
    input  logic [LANE_W-1:0] wr_lane,
    input  logic [DATA_W-1:0] wr_data,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata,
    input  logic              rd_byte,
    input  logic [LANE_W-1:0] rd_lane,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] rd_value
);
    logic [7:0] lane_bytes [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Enable and data for lane i.
        always_comb begin
            be[i]          = wr_byte ? (wr_lane == LANE_W'(i)) : 1'b1;
            wdata[i*8 +: 8] = wr_byte ? wr_data[7:0] : wr_data[i*8 +: 8];
            lane_bytes[i]  = rdata[i*8 +: 8];
        end
    end

    // Zero-extended byte or full word on the read side.
    always_comb begin
        if (rd_byte) begin
            rd_value = {{(DATA_W-8){1'b0}}, lane_bytes[rd_lane]};
        end else begin
            rd_value = rdata;
        end
    end
endmodule

// File: rtl/memaddr_gen.sv
// Memory-operand address unit top. Stage 1 registers the memory port
// from the request; stage 2 registers the load result and the base
// register writeback. Assumes mem_rdata is valid in the cycle that the
// port presents a read.
module memaddr_gen
    import mag_pkg::*;
#(
    parameter logic [REG_W-1:0] SP_IDX     = 4'd14,
    parameter int               STACK_STEP = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [2:0]          req_kind,
    input  logic [MODE_W-1:0]   req_mode,
    input  logic [REG_W-1:0]    req_dst,
    output logic [REG_W-1:0]    base_sel,
    input  logic [DATA_W-1:0]   base_val,
    input  logic [DATA_W-1:0]   sp_val,
    input  logic [DATA_W-1:0]   imm,
    input  logic [DATA_W-1:0]   store_data,
    output logic                mem_en,
    output logic                mem_we,
    output logic [PADDR_W-1:0]  mem_addr,
    output logic [LANES-1:0]    mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                misalign_err,
    output logic                ld_valid,
    output logic [REG_W-1:0]    ld_idx,
    output logic [DATA_W-1:0]   ld_data,
    output logic                wb_valid,
    output logic [REG_W-1:0]    wb_idx,
    output logic [DATA_W-1:0]   wb_data
);
    mclass_e              cls;
    logic                 is_load;
    logic                 is_store;
    logic                 is_byte;
    logic                 is_code;
    logic                 is_word_data;
    logic [PADDR_W-1:0]   paddr;
    logic                 agu_wb_en;
    logic [REG_W-1:0]     agu_wb_idx;
    logic [DATA_W-1:0]   agu_wb_data;
    logic                 bad_align;
    logic                 go;
    logic [LANES-1:0]     req_be;
    logic [DATA_W-1:0]    req_wdata;
    logic [DATA_W-1:0]    rd_value;

    // Stage 1 side state not visible on the port.
    logic                 s1_load;
    logic                 s1_byte;
    logic [LANE_W-1:0]    s1_lane;
    logic [REG_W-1:0]     s1_dst;
    logic                 s1_wb_en;
    logic [REG_W-1:0]     s1_wb_idx;
    logic [DATA_W-1:0]    s1_wb_data;

    // Kind decode of the request.
    always_comb begin
        is_load      = 1'b0;
        is_store     = 1'b0;
        is_byte      = 1'b0;
        is_code      = 1'b0;
        is_word_data = 1'b0;
        unique case (req_kind)
            K_LDW:   begin is_load  = 1'b1; is_word_data = 1'b1; end
            K_STW:   begin is_store = 1'b1; is_word_data = 1'b1; end
            K_LDB:   begin is_load  = 1'b1; is_byte = 1'b1; end
            K_STB:   begin is_store = 1'b1; is_byte = 1'b1; end
            K_LDC:   begin is_load  = 1'b1; is_code = 1'b1; end
            K_STC:   begin is_store = 1'b1; is_code = 1'b1; end
            default: ;
        endcase
    end

    mag_decode #(
        .SP_IDX (SP_IDX)
    ) u_decode (
        .mode (req_mode),
        .code (is_code),
        .cls  (cls),
        .sel  (base_sel)
    );

    mag_agu #(
        .SP_IDX     (SP_IDX),
        .STACK_STEP (STACK_STEP)
    ) u_agu (
        .cls      (cls),
        .mode     (req_mode),
        .base_val (base_val),
        .sp_val   (sp_val),
        .imm      (imm),
        .paddr    (paddr),
        .wb_en    (agu_wb_en),
        .wb_idx   (agu_wb_idx),
        .wb_data  (agu_wb_data)
    );

    mag_lane u_lane (
        .wr_byte  (is_byte),
        .wr_lane  (paddr[LANE_W-1:0]),
        .wr_data  (store_data),
        .be       (req_be),
        .wdata    (req_wdata),
        .rd_byte  (s1_byte),
        .rd_lane  (s1_lane),
        .rdata    (mem_rdata),
        .rd_value (rd_value)
    );

    // Odd word data addresses are rejected; byte and code paths never are.
    assign bad_align = req_valid & is_word_data & paddr[0];
    assign go        = req_valid & (is_load | is_store) & ~bad_align;

    // Stage 1: register the memory port and the pending writeback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_en       <= 1'b0;
            mem_we       <= 1'b0;
            mem_addr     <= '0;
            mem_be       <= '0;
            mem_wdata    <= '0;
            misalign_err <= 1'b0;
            s1_load      <= 1'b0;
            s1_byte      <= 1'b0;
            s1_lane      <= '0;
            s1_dst       <= '0;
            s1_wb_en     <= 1'b0;
            s1_wb_idx    <= '0;
            s1_wb_data   <= '0;
        end else begin
            mem_en       <= go;
            mem_we       <= go & is_store;
            mem_addr     <= paddr;
            mem_be       <= go ? req_be : '0;
            mem_wdata    <= req_wdata;
            misalign_err <= bad_align;
            s1_load      <= go & is_load;
            s1_byte      <= is_byte;
            s1_lane      <= paddr[LANE_W-1:0];
            s1_dst       <= req_dst;
            s1_wb_en     <= go & agu_wb_en;
            s1_wb_idx    <= agu_wb_idx;
            s1_wb_data   <= agu_wb_data;
        end
    end

    // Stage 2: load result and writeback; the load wins a register clash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid <= 1'b0;
            ld_idx   <= '0;
            ld_data  <= '0;
            wb_valid <= 1'b0;
            wb_idx   <= '0;
            wb_data  <= '0;
        end else begin
            ld_valid <= s1_load;
            ld_idx   <= s1_dst;
            ld_data  <= rd_value;
            wb_valid <= s1_wb_en & ~(s1_load & (s1_wb_idx == s1_dst));
            wb_idx   <= s1_wb_idx;
            wb_data  <= s1_wb_data;
        end
    end
endmodule

// File: rtl/mag_checker.sv
// Port-level properties of memaddr_gen, bound to every instance.
module mag_checker
    import mag_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               mem_en,
    input logic               mem_we,
    input logic [PADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]   mem_be,
    input logic               misalign_err,
    input logic               ld_valid,
    input logic [REG_W-1:0]   ld_idx,
    input logic               wb_valid,
    input logic [REG_W-1:0]   wb_idx
);
    // An error cycle carries no access (R9).
    p_err_blocks_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_err |-> !mem_en);

    // An error leaves no result behind (R9).
    p_err_no_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_err |=> (!ld_valid && !wb_valid));

    // Full-word accesses reach the port even-aligned (R6).
    p_word_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && (mem_be == 2'b11)) |-> !mem_addr[0]);

    // A partial access enables exactly the lane of its address (R6).
    p_byte_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && (mem_be != 2'b11)) |->
            (($countones(mem_be) == 1) && (mem_be[1] == mem_addr[0]) && !mem_addr[16]));

    // A load result follows a read one cycle earlier (R11).
    p_ld_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_en && !mem_we));

    // Writes never produce a load result (R11).
    p_store_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |=> !ld_valid);

    // Load and writeback never target the same register together (R10).
    p_no_clash_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && wb_valid) |-> (ld_idx != wb_idx));
endmodule

bind memaddr_gen mag_checker u_mag_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_en       (mem_en),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_be       (mem_be),
    .misalign_err (misalign_err),
    .ld_valid     (ld_valid),
    .ld_idx       (ld_idx),
    .wb_valid     (wb_valid),
    .wb_idx       (wb_idx)
);

// File: tb/memaddr_gen_tb.sv
`timescale 1ns/1ps
module memaddr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [7:0]  req_mode = '0;
    logic [3:0]  req_dst = '0;
    logic [3:0]  base_sel;
    logic [15:0] base_val = '0;
    logic [15:0] sp_val = '0;
    logic [15:0] imm = '0;
    logic [15:0] store_data = '0;
    logic        mem_en;
    logic        mem_we;
    logic [16:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        misalign_err;
    logic        ld_valid;
    logic [3:0]  ld_idx;
    logic [15:0] ld_data;
    logic        wb_valid;
    logic [3:0]  wb_idx;
    logic [15:0] wb_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    // Memory model: word content is a function of the word address.
    function automatic logic [15:0] word_at(input logic [16:0] a);
        logic [31:0] p;
        p = {16'h0, a[16:1]} * 32'h9E37 + 32'h1234;
        return p[15:0];
    endfunction
    assign mem_rdata = word_at(mem_addr);

    memaddr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_mode(req_mode), .req_dst(req_dst), .base_sel(base_sel),
        .base_val(base_val), .sp_val(sp_val), .imm(imm), .store_data(store_data),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .misalign_err(misalign_err),
        .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_data(ld_data),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One request end to end against a model built from the requirements.
    task automatic run_one(input logic [2:0] k, input logic [7:0] m, input logic [3:0] d,
                           input logic [15:0] bv, input logic [15:0] sv,
                           input logic [15:0] iv, input logic [15:0] sd);
        logic        ld, st, byt, code, legal;
        logic [15:0] a16;
        logic [16:0] ea;
        logic        has_wb, err, acc;
        logic [3:0]  widx, esel;
        logic [15:0] wval, wd, rw, ldexp;
        logic [1:0]  be;
        string       rq;
        ld   = (k == 0) || (k == 2) || (k == 4);
        st   = (k == 1) || (k == 3) || (k == 5);
        byt  = (k == 2) || (k == 3);
        code = (k == 4) || (k == 5);
        legal = ld || st;
        has_wb = 1'b0; widx = m[3:0]; wval = 16'h0; a16 = bv; esel = m[3:0];
        if (code) begin
            rq = "R8";
        end else if (m < 8'h0f) begin
            rq = "R1"; a16 = bv;
        end else if (m == 8'h0f) begin
            rq = "R2"; a16 = sv - 16'd2; has_wb = 1'b1; widx = 4'd14; wval = sv - 16'd2; esel = 4'd14;
        end else if (m < 8'h1f) begin
            rq = "R3"; a16 = bv + iv;
        end else if (m == 8'h1f) begin
            rq = "R3"; a16 = iv;
        end else if (m < 8'h2f) begin
            rq = "R4"; a16 = bv; has_wb = 1'b1; wval = bv + iv;
        end else if (m == 8'h2f) begin
            rq = "R4"; a16 = sv; has_wb = 1'b1; widx = 4'd14; wval = sv + 16'd2; esel = 4'd14;
        end else begin
            rq = "R5"; a16 = sv + {8'h0, m} - 16'h0030; esel = 4'd14;
        end
        ea  = code ? {bv, 1'b0} : {1'b0, a16};
        err = (k == 0 || k == 1) && ea[0];
        acc = legal && !err;
        be  = byt ? (ea[0] ? 2'b10 : 2'b01) : 2'b11;
        wd  = byt ? {sd[7:0], sd[7:0]} : sd;
        rw  = word_at(ea);
        ldexp = byt ? {8'h0, (ea[0] ? rw[15:8] : rw[7:0])} : rw;

        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_mode = m; req_dst = d;
        base_val = bv; sp_val = sv; imm = iv; store_data = sd;
        #1;
        if (legal) check(base_sel == esel, "R12", "base_sel", base_sel, esel);
        @(negedge clk);
        req_valid = 1'b0;
        check(misalign_err == err, "R9", "misalign_err", misalign_err, err);
        check(mem_en == acc, legal ? rq : "R11", "mem_en", mem_en, acc);
        if (acc) begin
            check(mem_addr == ea, rq, "mem_addr", mem_addr, ea);
            check(mem_we == st, "R6", "mem_we", mem_we, st);
            check(mem_be == be, "R6", "mem_be", mem_be, be);
            if (st) check(mem_wdata == wd, "R6", "mem_wdata", mem_wdata, wd);
        end
        @(negedge clk);
        check(ld_valid == (acc && ld), "R11", "ld_valid", ld_valid, acc && ld);
        if (acc && ld) begin
            check(ld_data == ldexp, "R7", "ld_data", ld_data, ldexp);
            check(ld_idx == d, "R7", "ld_idx", ld_idx, d);
        end
        if (acc && has_wb && !code) begin
            if (ld && widx == d) begin
                check(wb_valid == 1'b0, "R10", "wb_valid", wb_valid, 0);
            end else begin
                check(wb_valid == 1'b1, rq, "wb_valid", wb_valid, 1);
                check(wb_idx == widx, rq, "wb_idx", wb_idx, widx);
                check(wb_data == wval, rq, "wb_data", wb_data, wval);
            end
        end else begin
            check(wb_valid == 1'b0, err ? "R9" : rq, "wb_valid", wb_valid, 0);
        end
        check(misalign_err == 1'b0, "R9", "misalign_err pulse", misalign_err, 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL R11 watchdog expired: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!mem_en && !misalign_err && !ld_valid && !wb_valid, "R11", "reset outputs",
              {mem_en, misalign_err, ld_valid, wb_valid}, 0);
        rst_n = 1'b1;

        // Sweep every mode for the four data kinds, even and odd operands.
        for (int v = 0; v < 2; v++) begin
            for (int k = 0; k < 4; k++) begin
                for (int mi = 0; mi < 256; mi++) begin
                    logic [7:0]  m;
                    logic [15:0] bv, sv, iv, sd;
                    logic [3:0]  d;
                    m  = mi[7:0];
                    bv = {m, ~m} ^ 16'(v + 2 * k);
                    sv = 16'h7F00 + 16'(v) + 16'(4 * k);
                    iv = 16'h0102 * 16'(mi + 1) + 16'(k);
                    sd = {~m, m} + 16'(v);
                    d  = (v == 1) ? m[3:0] : (m[3:0] + 4'd5);
                    if (v == 1 && (m == 8'h0f || m == 8'h2f)) d = 4'd14;
                    run_one(k[2:0], m, d, bv, sv, iv, sd);
                end
            end
        end

        // R8 code-word accesses, including the top of the 128 kB space.
        for (int i = 0; i < 6; i++) begin
            logic [15:0] bv;
            bv = (i == 5) ? 16'hFFFF : 16'h1357 * 16'(i + 1);
            run_one(3'd4, {4'h2, 4'(i)}, 4'(i), bv, 16'h7F01, 16'h0040, 16'h0);
            run_one(3'd5, {4'h0, 4'(i + 7)}, 4'(i), bv, 16'h7F01, 16'h0040, 16'hC3A5 + 16'(i));
        end

        // R11 reserved kinds produce nothing; R10 directed pop into r14.
        run_one(3'd6, 8'h2f, 4'd1, 16'h1000, 16'h2000, 16'h0002, 16'h0);
        run_one(3'd7, 8'h0f, 4'd1, 16'h1000, 16'h2000, 16'h0002, 16'h0);
        run_one(3'd0, 8'h2f, 4'd14, 16'h0, 16'h4000, 16'h0, 16'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule